// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block sends and receives asynchronous serial frames whose shape is chosen at run time. The shape covers the data length (4 to 16 bits), an optional even or odd parity bit, and one or two stop bits. Words enter and leave on parallel ports with valid/ready handshakes. An external baud-tick input paces the serial lines. The tick runs at `OVS` times the bit rate, and the receiver samples each bit once, near its middle.

A bank of external trigger lines feeds a single selected channel through a synchronizer. A rising edge on that channel can switch the transmitter or the receiver on. While the channel stays high it can also keep the transmitter sending filler frames. Explicit set and clear commands also control both enables. Each direction captures the frame format when a frame begins, so a format change never corrupts a frame that is already on the line.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset, `txd` is high, `tx_en`, `rx_en`, `rx_valid`, `tx_ready`, `rx_par_err` and `rx_frame_err` are low.
- R2: Length code k in 1..13 gives k+3 data bits. Data go out least significant bit first. The received word is right-aligned in `rx_data` with its upper bits zero.
- R3: A frame is one low start bit, the data bits, the parity bit when enabled, and then one stop bit (or two) at the high level. Each bit lasts `OVS` baud ticks, so `tx_ready` stays low for exactly `OVS`×(bit count) ticks after a handshake.
- R4: Parity code 0 means no parity, 2 means even parity and 3 means odd parity. The transmitted parity bit makes the count of ones over data plus parity even (code 2) or odd (code 3).
- R5: The receiver sets `rx_par_err` with the word when the received parity bit does not match the selected parity.
- R6: With `cfg_two_stop` high, the transmitter sends two stop bits. The receiver checks only the first one, and a low second stop bit neither raises an error nor starts a new frame.
- R7: The receiver sets `rx_frame_err` with the word when the first stop bit is sampled low.
- R8: A length code of 0, 14 or 15 selects 8 data bits. Parity code 1 selects no parity.
- R9: With `cfg_tx_trig_en` set, a rising edge on trigger channel `cfg_trig_sel` sets `tx_en`. A channel held high gives one event only, and other channels have no effect.
- R10: With `cfg_rx_trig_en` set, a rising edge on the selected channel sets `rx_en`. With it clear, the edge leaves `rx_en` unchanged.
- R11: While the selected channel is high, `cfg_auto_trig_en` is set and `tx_en` is high, an idle transmitter with no pending word sends an all-zero frame. A word offered on `tx_valid` in the same cycle is sent instead of the filler.
- R12: The receiver starts frames only while `rx_en` is high. `rx_valid` holds its word until `rx_ready` accepts it.
- R13: `tx_en_set`/`rx_en_set` set the matching enable and `tx_en_clr`/`rx_en_clr` clear it. When a clear and a set arrive in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| cfg_len_code | input | 4 | Data-length code (1..13 → 4..16 bits) |
| cfg_par_code | input | 2 | Parity code: 0 none, 2 even, 3 odd |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_trig_sel | input | 4 | Trigger channel index |
| cfg_tx_trig_en | input | 1 | Trigger edge sets tx_en |
| cfg_rx_trig_en | input | 1 | Trigger edge sets rx_en |
| cfg_auto_trig_en | input | 1 | Trigger level holds filler transmission |
| trig_in | input | 16 | External trigger channels |
| tx_en_set | input | 1 | Set transmitter enable |
| tx_en_clr | input | 1 | Clear transmitter enable |
| rx_en_set | input | 1 | Set receiver enable |
| rx_en_clr | input | 1 | Clear receiver enable |
| tx_en | output | 1 | Transmitter enable state |
| rx_en | output | 1 | Receiver enable state |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Transmitter idle and enabled |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word accepted |
| rx_par_err | output | 1 | Parity mismatch on the held word |
| rx_frame_err | output | 1 | Low first stop bit on the held word |

## Verification
Automatic filler transmission and a real word offered by the user can both be due in the one idle cycle between back-to-back filler frames. The bench holds the trigger high so that filler frames run continuously. It then raises `tx_valid` and lets the handshake land in one of those idle cycles. It judges the result through the looped-back receiver: the frame after the handshake must carry the offered word and not zeros. A second collision, an enable set and clear in the same cycle, is forced directly on the command pins, and the bench checks that the enable ends low.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int DATA_W = 16;
   localparam int CNT_W  = 5;

   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP, PH_STOP2
   } phase_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0, PAR_RSVD = 2'd1, PAR_EVEN = 2'd2, PAR_ODD = 2'd3
   } par_code_e;

   typedef struct packed {
      logic [CNT_W-1:0] nbits;
      logic             par_on;
      logic             par_odd;
      logic             two_stop;
   } fmt_t;

   function automatic fmt_t decode_fmt(input logic [3:0] len_code,
                                       input logic [1:0] par_code,
                                       input logic       two);
      fmt_t f;
      if (len_code >= 4'd1 && len_code <= 4'd13)
         f.nbits = CNT_W'(len_code) + CNT_W'(3);
      else
         f.nbits = CNT_W'(8);
      case (par_code_e'(par_code))
         PAR_EVEN: begin f.par_on = 1'b1; f.par_odd = 1'b0; end
         PAR_ODD:  begin f.par_on = 1'b1; f.par_odd = 1'b1; end
         default:  begin f.par_on = 1'b0; f.par_odd = 1'b0; end
      endcase
      f.two_stop = two;
      return f;
   endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic din;
      logic flop;
      if (g == 0) begin : g_head
         assign din = d;
      end else begin : g_tail
         assign din = g_stage[g-1].flop;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flop <= RST_VAL;
         else        flop <= din;
      end
   end
   assign q = g_stage[STAGES-1].flop;
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
   import sfe_pkg::*;
#(
   parameter int OVS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              auto_on,
   input  fmt_t              fmt_in,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              txd
);
   localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;

   phase_e            ph;
   logic [CW-1:0]     tcnt;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  left;
   fmt_t              fmt;
   logic              par_bit;
   logic              idle, go, bit_end;

   assign idle     = (ph == PH_IDLE);
   assign tx_ready = tx_en && idle;
   assign go       = tx_en && idle && (tx_valid || auto_on);
   assign bit_end  = baud_tick && (tcnt == CW'(OVS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         tcnt    <= '0;
         sh      <= '0;
         left    <= '0;
         fmt     <= '0;
         par_bit <= 1'b0;
      end else if (go) begin
         ph      <= PH_START;
         tcnt    <= '0;
         sh      <= tx_valid ? tx_data : '0;
         fmt     <= fmt_in;
         left    <= fmt_in.nbits;
         par_bit <= fmt_in.par_odd;
      end else if (!idle && baud_tick) begin
         tcnt <= bit_end ? '0 : tcnt + CW'(1);
         if (bit_end) begin
            case (ph)
               PH_START: ph <= PH_DATA;
               PH_DATA: begin
                  par_bit <= par_bit ^ sh[0];
                  sh      <= sh >> 1;
                  left    <= left - CNT_W'(1);
                  if (left == CNT_W'(1)) ph <= fmt.par_on ? PH_PAR : PH_STOP;
               end
               PH_PAR:  ph <= PH_STOP;
               PH_STOP: ph <= fmt.two_stop ? PH_STOP2 : PH_IDLE;
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (ph)
         PH_START: txd = 1'b0;
         PH_DATA:  txd = sh[0];
         PH_PAR:   txd = par_bit;
         default:  txd = 1'b1;
      endcase
   end

   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !txd);
   a_r3_stop_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> $past(txd));
   a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !tx_ready);
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
   import sfe_pkg::*;
#(
   parameter int OVS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx_en,
   input  fmt_t              fmt_in,
   input  logic              rxd_s,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic              rx_par_err,
   output logic              rx_frame_err
);
   localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;

   phase_e            ph;
   logic [CW-1:0]     tcnt;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  left;
   fmt_t              fmt;
   logic              par_acc, par_bad, prev;
   logic              t_last, t_half;

   assign t_last = baud_tick && (tcnt == CW'(OVS-1));
   assign t_half = baud_tick && (tcnt == CW'(OVS/2-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph           <= PH_IDLE;
         tcnt         <= '0;
         sh           <= '0;
         left         <= '0;
         fmt          <= '0;
         par_acc      <= 1'b0;
         par_bad      <= 1'b0;
         prev         <= 1'b1;
         rx_data      <= '0;
         rx_valid     <= 1'b0;
         rx_par_err   <= 1'b0;
         rx_frame_err <= 1'b0;
      end else begin
         if (rx_valid && rx_ready) rx_valid <= 1'b0;
         case (ph)
            PH_IDLE: if (baud_tick) begin
               prev <= rxd_s;
               if (rx_en && prev && !rxd_s) begin
                  ph      <= PH_START;
                  tcnt    <= '0;
                  fmt     <= fmt_in;
                  left    <= fmt_in.nbits;
                  par_acc <= fmt_in.par_odd;
                  par_bad <= 1'b0;
                  sh      <= '0;
               end
            end
            PH_START: if (baud_tick) begin
               if (t_half) begin
                  tcnt <= '0;
                  ph   <= rxd_s ? PH_IDLE : PH_DATA;
                  prev <= rxd_s;
               end else begin
                  tcnt <= tcnt + CW'(1);
               end
            end
            default: if (baud_tick) begin
               tcnt <= t_last ? '0 : tcnt + CW'(1);
               if (t_last) begin
                  case (ph)
                     PH_DATA: begin
                        sh      <= {rxd_s, sh[DATA_W-1:1]};
                        par_acc <= par_acc ^ rxd_s;
                        left    <= left - CNT_W'(1);
                        if (left == CNT_W'(1)) ph <= fmt.par_on ? PH_PAR : PH_STOP;
                     end
                     PH_PAR: begin
                        par_bad <= par_acc ^ rxd_s;
                        ph      <= PH_STOP;
                     end
                     PH_STOP: begin
                        rx_data      <= sh >> (CNT_W'(DATA_W) - fmt.nbits);
                        rx_valid     <= 1'b1;
                        rx_par_err   <= par_bad;
                        rx_frame_err <= !rxd_s;
                        ph           <= fmt.two_stop ? PH_STOP2 : PH_IDLE;
                        prev         <= rxd_s;
                     end
                     default: begin
                        ph   <= PH_IDLE;
                        prev <= rxd_s;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   a_r12_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid);
   a_r12_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) && !rx_en |=> (ph == PH_IDLE));
   a_r7_err_with_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_frame_err) |-> $rose(rx_valid) || rx_valid);
endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
   import sfe_pkg::*;
#(
   parameter int OVS         = 4,
   parameter int TRIG_CH     = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(TRIG_CH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic [3:0]         cfg_len_code,
   input  logic [1:0]         cfg_par_code,
   input  logic               cfg_two_stop,
   input  logic [SEL_W-1:0]   cfg_trig_sel,
   input  logic               cfg_tx_trig_en,
   input  logic               cfg_rx_trig_en,
   input  logic               cfg_auto_trig_en,
   input  logic [TRIG_CH-1:0] trig_in,
   input  logic               tx_en_set,
   input  logic               tx_en_clr,
   input  logic               rx_en_set,
   input  logic               rx_en_clr,
   output logic               tx_en,
   output logic               rx_en,
   input  logic [DATA_W-1:0]  tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic               txd,
   input  logic               rxd,
   output logic [DATA_W-1:0]  rx_data,
   output logic               rx_valid,
   input  logic               rx_ready,
   output logic               rx_par_err,
   output logic               rx_frame_err
);
   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 2");
   end
   if (TRIG_CH < 2) begin : g_bad_ch
      $error("TRIG_CH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   fmt_t fmt_now;
   logic trig_pick, trig_lvl, trig_lvl_d, trig_rise, auto_on, rxd_s;
   logic tx_en_q, rx_en_q;

   assign fmt_now   = decode_fmt(cfg_len_code, cfg_par_code, cfg_two_stop);
   assign trig_pick = trig_in[cfg_trig_sel];

   sfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_trig_sync (
      .clk(clk), .rst_n(rst_n), .d(trig_pick), .q(trig_lvl));
   sfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rxd_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_lvl_d <= 1'b0;
      else        trig_lvl_d <= trig_lvl;
   end
   assign trig_rise = trig_lvl && !trig_lvl_d;
   assign auto_on   = trig_lvl && cfg_auto_trig_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q <= 1'b0;
         rx_en_q <= 1'b0;
      end else begin
         if (tx_en_clr)                                        tx_en_q <= 1'b0;
         else if (tx_en_set || (trig_rise && cfg_tx_trig_en))  tx_en_q <= 1'b1;
         if (rx_en_clr)                                        rx_en_q <= 1'b0;
         else if (rx_en_set || (trig_rise && cfg_rx_trig_en))  rx_en_q <= 1'b1;
      end
   end
   assign tx_en = tx_en_q;
   assign rx_en = rx_en_q;

   sfe_tx #(.OVS(OVS)) i_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en_q),
      .auto_on(auto_on), .fmt_in(fmt_now), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd));

   sfe_rx #(.OVS(OVS)) i_rx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en_q),
      .fmt_in(fmt_now), .rxd_s(rxd_s), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_par_err(rx_par_err),
      .rx_frame_err(rx_frame_err));

   a_r13_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_clr |=> !tx_en);
   a_r9_tx_en_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> $past(tx_en_set || (trig_rise && cfg_tx_trig_en)));
   a_r10_rx_en_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |-> $past(rx_en_set || (trig_rise && cfg_rx_trig_en)));
   a_r9_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      trig_rise |=> !trig_rise);
endmodule

// File: tb/test_serial_frame_engine.sv
`timescale 1ns/1ps
module test_serial_frame_engine;
   localparam int OVS = 4;

   typedef struct packed {
      logic [3:0]  len;
      logic [1:0]  par;
      logic        two;
      logic [15:0] data;
      logic [15:0] exp;
      logic [7:0]  cyc;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{4'd5,  2'd0, 1'b0, 16'h00A5, 16'h00A5, 8'd40},
      '{4'd1,  2'd2, 1'b0, 16'h001B, 16'h000B, 8'd28},
      '{4'd13, 2'd3, 1'b1, 16'hBEEF, 16'hBEEF, 8'd80},
      '{4'd8,  2'd2, 1'b1, 16'h1234, 16'h0234, 8'd60},
      '{4'd0,  2'd1, 1'b0, 16'h01FF, 16'h00FF, 8'd40},
      '{4'd14, 2'd2, 1'b0, 16'hFFFF, 16'h00FF, 8'd44},
      '{4'd3,  2'd3, 1'b0, 16'h002A, 16'h002A, 8'd36},
      '{4'd10, 2'd0, 1'b1, 16'h5555, 16'h1555, 8'd64}
   };

   logic clk = 0, rst_n = 0, baud_tick = 1;
   logic [3:0] cfg_len_code = 4'd5;
   logic [1:0] cfg_par_code = 2'd0;
   logic cfg_two_stop = 0;
   logic [3:0] cfg_trig_sel = 4'd5;
   logic cfg_tx_trig_en = 0, cfg_rx_trig_en = 0, cfg_auto_trig_en = 0;
   logic [15:0] trig_in = '0;
   logic tx_en_set = 0, tx_en_clr = 0, rx_en_set = 0, rx_en_clr = 0;
   logic tx_en, rx_en, tx_ready, txd, rx_valid, rx_par_err, rx_frame_err;
   logic [15:0] tx_data = '0, rx_data;
   logic tx_valid = 0, rx_ready = 0;
   logic inj = 0, line = 1;
   logic rxd;
   int checks = 0, errors = 0;
   bit done = 0;

   assign rxd = inj ? line : txd;

   always #2.5 clk = ~clk;

   serial_frame_engine i_serial_frame_engine (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_len_code(cfg_len_code), .cfg_par_code(cfg_par_code),
      .cfg_two_stop(cfg_two_stop), .cfg_trig_sel(cfg_trig_sel),
      .cfg_tx_trig_en(cfg_tx_trig_en), .cfg_rx_trig_en(cfg_rx_trig_en),
      .cfg_auto_trig_en(cfg_auto_trig_en), .trig_in(trig_in),
      .tx_en_set(tx_en_set), .tx_en_clr(tx_en_clr),
      .rx_en_set(rx_en_set), .rx_en_clr(rx_en_clr),
      .tx_en(tx_en), .rx_en(rx_en), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_par_err(rx_par_err),
      .rx_frame_err(rx_frame_err));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1;
      @(negedge clk) s = 0;
   endtask

   task automatic take_rx();
      @(negedge clk) rx_ready = 1;
      @(negedge clk) rx_ready = 0;
   endtask

   task automatic start_tx(input logic [15:0] d);
      @(negedge clk);
      tx_data = d; tx_valid = 1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 0;
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (!tx_ready && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic wait_rx(input string req);
      int k = 0;
      while (!rx_valid && k < 300) begin
         k++;
         @(negedge clk);
      end
      if (!rx_valid) chk(req, 32'h0, 32'h1);
   endtask

   task automatic send_raw(input logic [31:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) line = bits[i];
         repeat (OVS-1) @(negedge clk);
      end
      @(negedge clk) line = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 txd", txd, 1);
      chk("R1 tx_en", tx_en, 0);
      chk("R1 rx_en", rx_en, 0);
      chk("R1 rx_valid", rx_valid, 0);
      chk("R1 tx_ready", tx_ready, 0);
      chk("R1 errs", {rx_par_err, rx_frame_err}, 0);
      @(negedge clk) rst_n = 1;
      repeat (4) @(negedge clk);

      // R13 enable commands
      pulse(tx_en_set);
      pulse(rx_en_set);
      chk("R13 tx_en set", tx_en, 1);
      chk("R13 rx_en set", rx_en, 1);
      repeat (10) @(negedge clk);

      // R2 R3 R4 R6 R8 vector table in loopback
      for (int v = 0; v < NV; v++) begin
         cfg_len_code = VEC[v].len;
         cfg_par_code = VEC[v].par;
         cfg_two_stop = VEC[v].two;
         start_tx(VEC[v].data);
         count_busy(n);
         chk($sformatf("R3 frame length vec%0d", v), n, VEC[v].cyc);
         wait_rx($sformatf("R2 rx arrives vec%0d", v));
         chk($sformatf("R2 R8 data vec%0d", v), rx_data, VEC[v].exp);
         chk($sformatf("R5 R7 no error vec%0d", v), {rx_par_err, rx_frame_err}, 0);
         repeat (3) @(negedge clk);
         chk($sformatf("R12 hold vec%0d", v), rx_valid, 1);
         take_rx();
         repeat (8) @(negedge clk);
      end

      // R4 parity bit value on txd: 8 data bits 0x07, parity slot after 37 cycles
      cfg_len_code = 4'd5; cfg_two_stop = 0;
      cfg_par_code = 2'd2;
      start_tx(16'h0007);
      repeat (37) @(negedge clk);
      chk("R4 even parity bit", txd, 1);
      count_busy(n); wait_rx("R4 rx"); take_rx(); repeat (8) @(negedge clk);
      cfg_par_code = 2'd3;
      start_tx(16'h0007);
      repeat (37) @(negedge clk);
      chk("R4 odd parity bit", txd, 0);
      count_busy(n); wait_rx("R4 rx"); take_rx(); repeat (8) @(negedge clk);

      // R5 parity checking with injected frames (stop, parity, 8 data, start)
      inj = 1;
      cfg_par_code = 2'd2;
      send_raw({21'h0, 1'b1, 1'b0, 8'h07, 1'b0}, 11);
      wait_rx("R5 rx");
      chk("R5 even mismatch flagged", rx_par_err, 1);
      take_rx(); repeat (8) @(negedge clk);
      send_raw({21'h0, 1'b1, 1'b1, 8'h07, 1'b0}, 11);
      wait_rx("R5 rx");
      chk("R5 even match clean", rx_par_err, 0);
      take_rx(); repeat (8) @(negedge clk);
      cfg_par_code = 2'd3;
      send_raw({21'h0, 1'b1, 1'b0, 8'h07, 1'b0}, 11);
      wait_rx("R5 rx");
      chk("R5 odd match clean", rx_par_err, 0);
      take_rx(); repeat (8) @(negedge clk);

      // R6 second stop low is ignored
      cfg_par_code = 2'd0; cfg_two_stop = 1;
      send_raw({21'h0, 1'b0, 1'b1, 8'hC3, 1'b0}, 11);
      wait_rx("R6 rx");
      chk("R6 data", rx_data, 16'h00C3);
      chk("R6 no frame error", rx_frame_err, 0);
      take_rx();
      repeat (60) @(negedge clk);
      chk("R6 no spurious frame", rx_valid, 0);

      // R7 framing error
      cfg_two_stop = 0;
      send_raw({22'h0, 1'b0, 8'h3C, 1'b0}, 10);
      wait_rx("R7 rx");
      chk("R7 frame error", rx_frame_err, 1);
      chk("R7 data", rx_data, 16'h003C);
      take_rx(); repeat (20) @(negedge clk);

      // R12 receiver disabled
      pulse(rx_en_clr);
      send_raw({22'h0, 1'b1, 8'h11, 1'b0}, 10);
      repeat (60) @(negedge clk);
      chk("R12 disabled no word", rx_valid, 0);
      inj = 0;

      // R13 clear wins over set
      @(negedge clk) begin tx_en_set = 1; tx_en_clr = 1; rx_en_set = 1; rx_en_clr = 1; end
      @(negedge clk) begin tx_en_set = 0; tx_en_clr = 0; rx_en_set = 0; rx_en_clr = 0; end
      chk("R13 tx clear wins", tx_en, 0);
      chk("R13 rx clear wins", rx_en, 0);

      // R9 transmit trigger
      cfg_tx_trig_en = 1;
      @(negedge clk) trig_in[3] = 1;
      repeat (6) @(negedge clk);
      chk("R9 other channel ignored", tx_en, 0);
      trig_in[3] = 0;
      @(negedge clk) trig_in[5] = 1;
      repeat (4) @(negedge clk);
      chk("R9 edge sets tx_en", tx_en, 1);
      chk("R10 rx trigger off ignored", rx_en, 0);
      pulse(tx_en_clr);
      repeat (8) @(negedge clk);
      chk("R9 held high single event", tx_en, 0);
      trig_in[5] = 0; cfg_tx_trig_en = 0;
      repeat (4) @(negedge clk);

      // R10 receive trigger
      cfg_rx_trig_en = 1;
      @(negedge clk) trig_in[5] = 1;
      repeat (4) @(negedge clk);
      chk("R10 edge sets rx_en", rx_en, 1);
      trig_in[5] = 0; cfg_rx_trig_en = 0;
      repeat (4) @(negedge clk);

      // R11 auto filler and precedence of a real word
      cfg_len_code = 4'd5; cfg_par_code = 2'd0; cfg_two_stop = 0;
      pulse(tx_en_set);
      cfg_auto_trig_en = 1;
      @(negedge clk) trig_in[5] = 1;
      wait_rx("R11 filler rx");
      chk("R11 filler is zero", rx_data, 16'h0000);
      rx_ready = 1;
      start_tx(16'h005A);
      trig_in[5] = 0;
      repeat (20) @(negedge clk);
      rx_ready = 0;
      wait_rx("R11 word rx");
      chk("R11 offered word wins", rx_data, 16'h005A);
      take_rx();
      cfg_auto_trig_en = 0;
      repeat (60) @(negedge clk);
      chk("R11 filler stops", rx_valid, 0);

      finish_run();
   end
endmodule